// File: doc/BRIEF.md
# Oversampling UART Receive Channel

This block receives asynchronous serial characters on a single line input. A shared bit-rate generator supplies a one-cycle tick at sixteen times the bit rate (the oversampling ratio is a parameter). The line is first passed through a short synchronizer. The receiver then hunts for a falling edge, confirms the start bit at its midpoint, and samples every following bit once at its midpoint. Each character has 7 or 8 data bits, sent least significant bit first, and may carry a parity bit. The format inputs are the same ones that set up the companion transmitter.

When the first stop bit is sampled, the received character moves into a one-entry holding buffer. At that same moment the overrun, parity and framing flags are latched together for that character. The shift path can then take in the next character while software, or a downstream consumer, still holds the previous one. The buffer is offered on a valid/ready output. `rx_valid` stays high until `rx_ready` is seen with it, and a pop clears the buffer. The serial line cannot be stalled, so back-pressure cannot stop reception. A character that completes while the buffer is still full overwrites it and raises the overrun flag. The receive interrupt pulses once each time the buffer goes from empty to full.

Top module: `uart_rx_channel`

## Requirements
- R1: After reset, `rx_valid`, `rx_irq` and all three error flags are 0 and `rx_data` is 0.
- R2: A low line seen on a tick arms start detection. On the 8th tick (the midpoint) the line is sampled again. If it is high, the start is rejected, nothing is stored and the receiver returns to hunting.
- R3: After a confirmed start, each bit is sampled once every 16 ticks at its midpoint. Data arrives least significant bit first and appears in `rx_data` unchanged.
- R4: With `cfg_len8`=0, 7 data bits are received and `rx_data[7]` reads 0. With `cfg_len8`=1, 8 data bits are received.
- R5: With `cfg_par_en`=1, one parity bit follows the data. `rx_par_err` is 1 when the count of ones over the data and parity bits is odd while `cfg_par_odd`=0, or even while `cfg_par_odd`=1. With `cfg_par_en`=0, `rx_par_err` is 0.
- R6: If the first stop bit samples low, `rx_frm_err` is 1. The receiver then waits for a high line on a tick before it looks for a new start, so a held-low line yields one character only.
- R7: At the midpoint of the first stop bit, the character is stored, `rx_valid` becomes 1 and all three flags are replaced together. `rx_ovr_err` is 1 if the buffer was still full and not popped in that cycle, and the new character then replaces the old one.
- R8: A cycle with `rx_valid` and `rx_ready` both high pops the buffer. From the next cycle, `rx_valid` and all three flags are 0, unless a new character is stored in that same cycle.
- R9: `rx_irq` is a one-cycle pulse in the cycle `rx_valid` goes from 0 to 1, including a pop and a store in the same cycle. A store over a held character gives no pulse.
- R10: While the buffer holds a character that is not popped, `rx_data` stays unchanged as the next character is shifted in, until that next character is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling tick, 16 per bit time |
| rxd | input | 1 | Serial line, idle high |
| cfg_len8 | input | 1 | 1: 8 data bits, 0: 7 data bits |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| rx_data | output | 8 | Held character |
| rx_valid | output | 1 | Buffer full |
| rx_ready | input | 1 | Consumer takes the character |
| rx_ovr_err | output | 1 | Overrun for the held character |
| rx_par_err | output | 1 | Parity error for the held character |
| rx_frm_err | output | 1 | Framing error for the held character |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The bench uses the default parameters: 16 ticks per bit, a two-stage synchronizer and an 8-bit buffer. Ticks are driven every fourth clock, so one bit lasts 64 clocks. This puts the midpoint sample well clear of the bit edges, even with the tick phase and the synchronizer delay added. It also keeps a full frame short enough to send glitches, both character lengths, both parity senses, a held break and an overrun within a few thousand cycles. A behavioural model driven by the same line and tick is compared with every output on every clock.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_BREAK
  } rx_state_e;

  typedef struct packed {
    logic len8;
    logic par_en;
    logic par_odd;
  } rx_fmt_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] s;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) s[0] <= 1'b1;
        else        s[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) s[i] <= 1'b1;
        else        s[i] <= s[i-1];
    end
  end

  assign q = s[STAGES-1];
endmodule

// File: rtl/rx_frame_fsm.sv
module rx_frame_fsm
  import rxc_pkg::*;
#(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              rxs,
  input  rx_fmt_t           fmt,
  output logic              load,
  output logic [DATA_W-1:0] load_data,
  output logic              load_perr,
  output logic              load_ferr
);
  localparam int CW = (OSR > 2) ? $clog2(OSR) : 1;
  localparam int BW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] MID_LAST = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] SMP_LAST = CW'(OSR - 1);
  localparam logic [BW-1:0] LAST_LONG  = BW'(DATA_W - 1);
  localparam logic [BW-1:0] LAST_SHORT = BW'(DATA_W - 2);

  rx_state_e         state;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bidx;
  logic [DATA_W-1:0] sr;
  logic              par_bit;
  logic              sample;
  logic [BW-1:0]     last_idx;

  assign sample   = tick && (cnt == SMP_LAST);
  assign last_idx = fmt.len8 ? LAST_LONG : LAST_SHORT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bidx    <= '0;
      sr      <= '0;
      par_bit <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (tick && !rxs) begin
          state <= ST_START;
          cnt   <= CW'(1);
        end
        ST_START: if (tick) begin
          if (cnt == MID_LAST) begin
            cnt <= '0;
            if (rxs) state <= ST_IDLE;
            else begin
              state <= ST_DATA;
              bidx  <= '0;
              sr    <= '0;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_DATA: if (tick) begin
          cnt <= cnt + 1'b1;
          if (sample) begin
            sr   <= {rxs, sr[DATA_W-1:1]};
            bidx <= bidx + 1'b1;
            if (bidx == last_idx) state <= fmt.par_en ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: if (tick) begin
          cnt <= cnt + 1'b1;
          if (sample) begin
            par_bit <= rxs;
            state   <= ST_STOP;
          end
        end
        ST_STOP: if (tick) begin
          cnt <= cnt + 1'b1;
          if (sample) state <= rxs ? ST_IDLE : ST_BREAK;
        end
        ST_BREAK: if (tick && rxs) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    load      = (state == ST_STOP) && sample;
    load_data = fmt.len8 ? sr : {1'b0, sr[DATA_W-1:1]};
    load_ferr = !rxs;
    load_perr = fmt.par_en && ((^load_data) ^ par_bit ^ fmt.par_odd);
  end

  a_r2_start_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_START && tick && cnt == MID_LAST && rxs) |=> state == ST_IDLE);

  a_r6_break_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_STOP && sample && !rxs) |=> state == ST_BREAK);

  a_r6_break_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BREAK && !rxs) |=> state != ST_START);

  a_r7_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !load);
endmodule

// File: rtl/rx_hold_buf.sv
module rx_hold_buf #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              len8,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              load_perr,
  input  logic              load_ferr,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              ovr,
  output logic              perr,
  output logic              ferr,
  output logic              irq
);
  logic pop;
  logic still_full;

  assign pop        = valid && ready;
  assign still_full = valid && !pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
      ovr   <= 1'b0;
      perr  <= 1'b0;
      ferr  <= 1'b0;
      irq   <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
      ovr   <= still_full;
      perr  <= load_perr;
      ferr  <= load_ferr;
      irq   <= !still_full;
    end else begin
      irq <= 1'b0;
      if (pop) begin
        valid <= 1'b0;
        ovr   <= 1'b0;
        perr  <= 1'b0;
        ferr  <= 1'b0;
      end
    end
  end

  a_r8_pop_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && ready && !load) |=> (!valid && !ovr && !perr && !ferr));

  a_r9_irq_only_full: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> valid);

  a_r9_rise_pulses: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> irq);

  a_r7_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (load && valid && !ready) |=> ovr);

  a_r4_short_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !len8) |=> !data[DATA_W-1]);

  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load) |=> $stable(data));
endmodule

// File: rtl/uart_rx_channel.sv
module uart_rx_channel
  import rxc_pkg::*;
#(
  parameter int OSR         = 16,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              os_tick,
  input  logic              rxd,
  input  logic              cfg_len8,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic              rx_ovr_err,
  output logic              rx_par_err,
  output logic              rx_frm_err,
  output logic              rx_irq
);
  rx_fmt_t           fmt;
  logic              rxs;
  logic              load;
  logic [DATA_W-1:0] load_data;
  logic              load_perr;
  logic              load_ferr;

  assign fmt = '{len8: cfg_len8, par_en: cfg_par_en, par_odd: cfg_par_odd};

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxs)
  );

  rx_frame_fsm #(.OSR(OSR), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .tick(os_tick), .rxs(rxs), .fmt(fmt),
    .load(load), .load_data(load_data), .load_perr(load_perr),
    .load_ferr(load_ferr)
  );

  rx_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .len8(cfg_len8), .load(load),
    .load_data(load_data), .load_perr(load_perr), .load_ferr(load_ferr),
    .ready(rx_ready), .valid(rx_valid), .data(rx_data), .ovr(rx_ovr_err),
    .perr(rx_par_err), .ferr(rx_frm_err), .irq(rx_irq)
  );
endmodule

// File: tb/tb_uart_rx_channel.sv
module tb_uart_rx_channel;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 4;
  localparam int OSR        = 16;
  localparam int SYNC       = 2;
  localparam int BITC       = TICK_DIV * OSR;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       os_tick = 1'b0;
  logic       rxd = 1'b1;
  logic       cfg_len8 = 1'b1, cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
  logic       rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       rx_valid, rx_ovr_err, rx_par_err, rx_frm_err, rx_irq;

  int checks = 0, errors = 0, irq_cnt = 0;
  bit done = 0;

  uart_rx_channel dut (
    .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .rxd(rxd),
    .cfg_len8(cfg_len8), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_ovr_err(rx_ovr_err), .rx_par_err(rx_par_err),
    .rx_frm_err(rx_frm_err), .rx_irq(rx_irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv    = (tdiv + 1) % TICK_DIV;
    os_tick <= (tdiv == 0);
  end

  always @(posedge clk) if (rst_n && rx_irq) irq_cnt++;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Behavioural reference: line history, phase counter, bit list
  logic ms [SYNC];
  int   mst, mc, mb;
  logic [7:0] mdat;
  logic mp;
  logic mv, movr, mperr, mferr, mirq;
  logic [7:0] mbuf;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC; i++) ms[i] = 1'b1;
      mst = 0; mc = 0; mb = 0; mdat = 0; mp = 0;
      mv = 0; movr = 0; mperr = 0; mferr = 0; mirq = 0; mbuf = 0;
    end else begin
      logic line, ld, lf, pop, full;
      int nb;
      line = ms[SYNC-1];
      nb   = cfg_len8 ? 8 : 7;
      ld = 0; lf = 0;
      if (os_tick) begin
        case (mst)
          0: if (!line) begin mst = 1; mc = 1; end
          1: if (mc == OSR / 2 - 1) begin
               mc = 0;
               if (line) mst = 0;
               else begin mst = 2; mb = 0; mdat = 0; end
             end else mc++;
          2: if (mc == OSR - 1) begin
               mc = 0; mdat[mb] = line; mb++;
               if (mb == nb) mst = cfg_par_en ? 3 : 4;
             end else mc++;
          3: if (mc == OSR - 1) begin mc = 0; mp = line; mst = 4; end else mc++;
          4: if (mc == OSR - 1) begin
               mc = 0; ld = 1; lf = !line; mst = line ? 0 : 5;
             end else mc++;
          default: if (line) mst = 0;
        endcase
      end
      pop  = mv && rx_ready;
      full = mv && !pop;
      if (ld) begin
        mv = 1; mbuf = mdat; movr = full; mferr = lf;
        mperr = cfg_par_en && ((($countones(mdat) + int'(mp)) % 2) != int'(cfg_par_odd));
        mirq = !full;
      end else begin
        mirq = 0;
        if (pop) begin mv = 0; movr = 0; mperr = 0; mferr = 0; end
      end
      for (int i = SYNC - 1; i > 0; i--) ms[i] = ms[i-1];
      ms[0] = rxd;
    end
  end

  always @(negedge clk)
    if (rst_n && !done)
      chk("R3/R7 per-cycle model {valid,ovr,perr,ferr,irq,data}",
          {19'd0, rx_valid, rx_ovr_err, rx_par_err, rx_frm_err, rx_irq, rx_data},
          {19'd0, mv, movr, mperr, mferr, mirq, mbuf});

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input bit flip, input bit stop_lo);
    int nb;
    logic [7:0] dm;
    nb = cfg_len8 ? 8 : 7;
    dm = cfg_len8 ? d : {1'b0, d[6:0]};
    rxd = 1'b0; wait_clks(BITC);
    for (int i = 0; i < nb; i++) begin rxd = dm[i]; wait_clks(BITC); end
    if (cfg_par_en) begin rxd = (^dm) ^ cfg_par_odd ^ flip; wait_clks(BITC); end
    rxd = !stop_lo; wait_clks(BITC);
    if (stop_lo) wait_clks(BITC * 2);
    rxd = 1'b1; wait_clks(BITC * 2);
  endtask

  task automatic pop_one;
    rx_ready = 1'b1; @(negedge clk);
    rx_ready = 1'b0; @(negedge clk);
  endtask

  initial begin
    int base;
    wait_clks(5);
    chk("R1 reset valid", 32'(rx_valid), 0);
    chk("R1 reset flags/irq", 32'({rx_ovr_err, rx_par_err, rx_frm_err, rx_irq}), 0);
    chk("R1 reset data", 32'(rx_data), 0);
    rst_n = 1'b1;
    wait_clks(BITC);

    // R3: 8-bit, no parity
    send(8'hA5, 0, 0);
    chk("R3 data 8-bit", 32'(rx_data), 32'hA5);
    chk("R7 valid after stop", 32'(rx_valid), 1);
    chk("R7 flags clear", 32'({rx_ovr_err, rx_par_err, rx_frm_err}), 0);
    chk("R9 one irq pulse", 32'(irq_cnt), 1);
    pop_one;
    chk("R8 pop clears valid", 32'(rx_valid), 0);

    // R2: short glitches are rejected
    rxd = 1'b0; wait_clks(12); rxd = 1'b1; wait_clks(BITC * 2);
    rxd = 1'b0; wait_clks(20); rxd = 1'b1; wait_clks(BITC * 2);
    chk("R2 glitch stores nothing", 32'(rx_valid), 0);
    chk("R2 glitch no irq", 32'(irq_cnt), 1);

    // R4: 7-bit mode
    cfg_len8 = 1'b0;
    send(8'hFF, 0, 0);
    chk("R4 7-bit msb zero", 32'(rx_data), 32'h7F);
    pop_one;
    send(8'h2B, 0, 0);
    chk("R4 7-bit data", 32'(rx_data), 32'h2B);
    pop_one;
    cfg_len8 = 1'b1;

    // R5: parity
    cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
    send(8'h3C, 0, 0);
    chk("R5 even parity good", 32'({rx_par_err, rx_data}), 32'h03C);
    pop_one;
    cfg_par_odd = 1'b1;
    send(8'h3D, 1, 0);
    chk("R5 odd parity bad", 32'({rx_par_err, rx_data}), 32'h13D);
    chk("R7 only parity flag", 32'({rx_ovr_err, rx_frm_err}), 0);
    pop_one;
    chk("R8 pop clears parity flag", 32'(rx_par_err), 0);
    cfg_par_en = 1'b0;

    // R6: framing error with held-low line
    base = irq_cnt;
    send(8'h5A, 0, 1);
    chk("R6 framing flag", 32'({rx_frm_err, rx_data}), 32'h15A);
    chk("R6 single char on break", 32'(irq_cnt - base), 1);
    pop_one;
    chk("R8 pop clears framing flag", 32'(rx_frm_err), 0);

    // R10 / R7: hold then overrun
    send(8'h11, 0, 0);
    base = irq_cnt;
    fork
      send(8'h22, 0, 0);
      begin
        wait_clks(BITC * 5);
        chk("R10 held data while shifting", 32'({rx_valid, rx_data}), 32'h111);
      end
    join
    chk("R7 overrun data replaced", 32'({rx_ovr_err, rx_data}), 32'h122);
    chk("R9 no irq when already full", 32'(irq_cnt - base), 0);
    pop_one;
    chk("R8 pop clears overrun", 32'({rx_valid, rx_ovr_err}), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R3 watchdog expired actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule